// File: doc/BRIEF.md
# Rename Physical Register Allocation Tracker

This block keeps, for each of several physical register files, a count of the physical registers that in-flight renamed writes currently hold. A fixed configuration maps every logical register to one owning file and to a cost, which is the number of physical registers a single rename of that register consumes. File 0 is special: it sees every logical register, so each charged write is counted there as well as in its owning file. Registers in the lowest quarter of the index space belong to file 0 alone.

At dispatch, the rename stage presents a group of destination registers on the query port. The block adds up the demand per file across the whole group. It returns a busy mask with one bit per file, and the group may dispatch only when the mask is all zero. When the group is renamed, an allocate strobe charges its costs. When those writes retire, a release strobe refunds the same costs. A file configured with capacity zero has no limit. Writes marked as zero idioms are never charged and never refunded. A read-only lookup port shows the owner and cost of any logical register. The per-file counts and a per-file underflow flag are brought out to the ports.

Top module: `rat_alloc_tracker`

## Requirements
- R1: After reset every used count is 0, every underflow flag is 0, and a query that fits every bounded file gives a busy mask of 0.
- R2: With default parameters, logical register r is owned by file r/4, and registers 0 to 3 are owned by file 0 alone. Registers 8 to 11 (file 2) cost 2 and all others cost 1. The lookup port returns this owner and cost for the index it is given.
- R3: On an allocate strobe, each enabled slot that is not a zero idiom adds its cost to its owning file and also to file 0. The new counts appear at the outputs after the next clock edge.
- R4: On a release strobe, each enabled slot that is not a zero idiom subtracts the same cost from the same files that allocation charged.
- R5: A slot flagged as a zero idiom changes no count, whether it is allocated or released.
- R6: Busy bit f is set exactly when used[f] plus the summed demand of the query group for file f exceeds the capacity of file f. Demand equal to the free space is not busy.
- R7: A file with capacity 0 (files 0 and 3 by default) never sets its busy bit.
- R8: Query demand is summed over all slots of the group. Slots whose enable bit is 0, and slots flagged as zero idioms, add nothing.
- R9: Allocate and release in the same cycle that touch the same file both take effect.
- R10: A release larger than the count clamps the count at 0. The underflow bit of that file is then 1 for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_en_i | input | GROUP | Query slot enables, bit 0 is slot 0 |
| q_zero_i | input | GROUP | Query slot zero-idiom flags |
| q_reg_i | input | GROUP*LREG_W | Query destination registers, slot 0 in the low bits |
| busy_o | output | NUM_FILES | Per-file lack-of-space mask for the query group |
| alloc_stb_i | input | 1 | Charge the allocate group this cycle |
| alloc_en_i | input | GROUP | Allocate slot enables |
| alloc_zero_i | input | GROUP | Allocate slot zero-idiom flags |
| alloc_reg_i | input | GROUP*LREG_W | Allocate destination registers |
| rel_stb_i | input | 1 | Refund the release group this cycle |
| rel_en_i | input | GROUP | Release slot enables |
| rel_zero_i | input | GROUP | Release slot zero-idiom flags |
| rel_reg_i | input | GROUP*LREG_W | Release destination registers |
| used_o | output | NUM_FILES*CNT_W | Per-file used counts, file 0 in the low bits |
| uflow_o | output | NUM_FILES | Per-file underflow flags |
| tbl_idx_i | input | LREG_W | Lookup index |
| tbl_owner_o | output | FIDX_W | Owning file of the looked-up register |
| tbl_cost_o | output | COST_W | Cost of the looked-up register |

## Verification
A wrong count shows on `used_o` in the first cycle after the strobe that caused it. It also changes `busy_o` combinationally for any query near that file's capacity, so a charge to the wrong file or of the wrong cost shows in both places. A wrong ownership or cost entry is visible at once on the lookup port. Clamping errors show as a nonzero count, or as a missing or stuck `uflow_o` bit, one cycle after the release.

// File: rtl/rat_pkg.sv
package rat_pkg;

  // Owning file: the logical index space is split evenly across files.
  function automatic int unsigned owner_of(input int unsigned lreg,
                                           input int unsigned n_lregs,
                                           input int unsigned n_files);
    int unsigned span;
    span = (n_lregs >= n_files) ? (n_lregs / n_files) : 1;
    return (lreg / span < n_files) ? (lreg / span) : 0;
  endfunction

  // Registers of the wide file consume two physical entries per rename.
  function automatic int unsigned cost_of(input int unsigned lreg,
                                          input int unsigned n_lregs,
                                          input int unsigned n_files,
                                          input int unsigned wide_file);
    return (owner_of(lreg, n_lregs, n_files) == wide_file) ? 2 : 1;
  endfunction

endpackage

// File: rtl/rat_slot_cost.sv
module rat_slot_cost #(
  parameter int NUM_FILES = 4,
  parameter int NUM_LREGS = 16,
  parameter int WIDE_FILE = 2,
  parameter int CNT_W     = 8,
  localparam int LREG_W   = $clog2(NUM_LREGS)
) (
  input  logic [LREG_W-1:0]          lreg_i,
  input  logic                       en_i,
  input  logic                       zero_i,
  output logic [NUM_FILES*CNT_W-1:0] charge_o
);
  import rat_pkg::*;

  int unsigned owner;
  logic [CNT_W-1:0] cost;

  always_comb begin
    owner    = owner_of(32'(lreg_i), NUM_LREGS, NUM_FILES);
    cost     = CNT_W'(cost_of(32'(lreg_i), NUM_LREGS, NUM_FILES, WIDE_FILE));
    charge_o = '0;
    if (en_i && !zero_i) begin
      // file 0 overlaps every register
      charge_o[0 +: CNT_W] = cost;
      for (int f = 1; f < NUM_FILES; f++) begin
        if (owner == f) charge_o[f*CNT_W +: CNT_W] = cost;
      end
    end
  end

endmodule

// File: rtl/rat_demand.sv
module rat_demand #(
  parameter int NUM_FILES = 4,
  parameter int NUM_LREGS = 16,
  parameter int WIDE_FILE = 2,
  parameter int GROUP     = 2,
  parameter int CNT_W     = 8,
  localparam int LREG_W   = $clog2(NUM_LREGS)
) (
  input  logic                       stb_i,
  input  logic [GROUP-1:0]           en_i,
  input  logic [GROUP-1:0]           zero_i,
  input  logic [GROUP*LREG_W-1:0]    reg_i,
  output logic [NUM_FILES*CNT_W-1:0] demand_o
);

  logic [NUM_FILES*CNT_W-1:0] slot_charge [GROUP];

  for (genvar g = 0; g < GROUP; g++) begin : g_slot
    rat_slot_cost #(
      .NUM_FILES(NUM_FILES), .NUM_LREGS(NUM_LREGS),
      .WIDE_FILE(WIDE_FILE), .CNT_W(CNT_W)
    ) i_cost (
      .lreg_i  (reg_i[g*LREG_W +: LREG_W]),
      .en_i    (stb_i & en_i[g]),
      .zero_i  (zero_i[g]),
      .charge_o(slot_charge[g])
    );
  end

  always_comb begin
    demand_o = '0;
    for (int f = 0; f < NUM_FILES; f++) begin
      for (int g = 0; g < GROUP; g++) begin
        demand_o[f*CNT_W +: CNT_W] = demand_o[f*CNT_W +: CNT_W]
                                   + slot_charge[g][f*CNT_W +: CNT_W];
      end
    end
  end

endmodule

// File: rtl/rat_file_ctr.sv
module rat_file_ctr #(
  parameter int CNT_W = 8,
  parameter int CAP   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] add_i,
  input  logic [CNT_W-1:0] sub_i,
  input  logic [CNT_W-1:0] need_i,
  output logic [CNT_W-1:0] used_o,
  output logic             busy_o,
  output logic             uflow_o
);
  localparam logic [CNT_W:0] MAX_CNT = {1'b0, {CNT_W{1'b1}}};
  localparam logic [CNT_W:0] CAP_W   = (CNT_W+1)'(CAP);

  logic [CNT_W-1:0] used_q, used_d;
  logic             uf_q, uf_d;
  logic             cnt_en;
  logic [CNT_W:0]   grown;

  // next state
  always_comb begin
    grown = {1'b0, used_q} + {1'b0, add_i};
    if (grown > MAX_CNT) grown = MAX_CNT;
    uf_d  = 1'b0;
    if ({1'b0, sub_i} > grown) begin
      used_d = '0;
      uf_d   = 1'b1;
    end else begin
      used_d = CNT_W'(grown - {1'b0, sub_i});
    end
    cnt_en = (add_i != '0) || (sub_i != '0);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
      uf_q   <= 1'b0;
    end else begin
      uf_q <= uf_d;
      if (cnt_en) used_q <= used_d;
    end
  end

  if (CAP == 0) begin : g_unbounded
    assign busy_o = 1'b0;
  end else begin : g_bounded
    assign busy_o = ({1'b0, used_q} + {1'b0, need_i}) > CAP_W;
  end

  assign used_o  = used_q;
  assign uflow_o = uf_q;

  // R10
  uf_implies_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf_q |-> (used_q == '0));

  // R3
  growth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, used_q} <= {1'b0, $past(used_q)} + {1'b0, $past(add_i)}));

  // R4
  shrink_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, used_q} + {1'b0, $past(sub_i)} >= {1'b0, $past(used_q)}));

endmodule

// File: rtl/rat_alloc_tracker.sv
module rat_alloc_tracker #(
  parameter int NUM_FILES  = 4,
  parameter int NUM_LREGS  = 16,
  parameter int GROUP      = 2,
  parameter int CNT_W      = 8,
  parameter int COST_W     = 2,
  parameter int WIDE_FILE  = 2,
  // per-file capacity, file 0 in the low byte; 0 means unlimited
  parameter logic [NUM_FILES*CNT_W-1:0] FILE_CAP = {8'd0, 8'd4, 8'd6, 8'd0},
  localparam int LREG_W    = $clog2(NUM_LREGS),
  localparam int FIDX_W    = (NUM_FILES > 1) ? $clog2(NUM_FILES) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [GROUP-1:0]           q_en_i,
  input  logic [GROUP-1:0]           q_zero_i,
  input  logic [GROUP*LREG_W-1:0]    q_reg_i,
  output logic [NUM_FILES-1:0]       busy_o,
  input  logic                       alloc_stb_i,
  input  logic [GROUP-1:0]           alloc_en_i,
  input  logic [GROUP-1:0]           alloc_zero_i,
  input  logic [GROUP*LREG_W-1:0]    alloc_reg_i,
  input  logic                       rel_stb_i,
  input  logic [GROUP-1:0]           rel_en_i,
  input  logic [GROUP-1:0]           rel_zero_i,
  input  logic [GROUP*LREG_W-1:0]    rel_reg_i,
  output logic [NUM_FILES*CNT_W-1:0] used_o,
  output logic [NUM_FILES-1:0]       uflow_o,
  input  logic [LREG_W-1:0]          tbl_idx_i,
  output logic [FIDX_W-1:0]          tbl_owner_o,
  output logic [COST_W-1:0]          tbl_cost_o
);
  import rat_pkg::*;

  logic [NUM_FILES*CNT_W-1:0] need, add, sub;

  rat_demand #(
    .NUM_FILES(NUM_FILES), .NUM_LREGS(NUM_LREGS), .WIDE_FILE(WIDE_FILE),
    .GROUP(GROUP), .CNT_W(CNT_W)
  ) i_query (
    .stb_i(1'b1), .en_i(q_en_i), .zero_i(q_zero_i), .reg_i(q_reg_i),
    .demand_o(need)
  );

  rat_demand #(
    .NUM_FILES(NUM_FILES), .NUM_LREGS(NUM_LREGS), .WIDE_FILE(WIDE_FILE),
    .GROUP(GROUP), .CNT_W(CNT_W)
  ) i_alloc (
    .stb_i(alloc_stb_i), .en_i(alloc_en_i), .zero_i(alloc_zero_i),
    .reg_i(alloc_reg_i), .demand_o(add)
  );

  rat_demand #(
    .NUM_FILES(NUM_FILES), .NUM_LREGS(NUM_LREGS), .WIDE_FILE(WIDE_FILE),
    .GROUP(GROUP), .CNT_W(CNT_W)
  ) i_release (
    .stb_i(rel_stb_i), .en_i(rel_en_i), .zero_i(rel_zero_i),
    .reg_i(rel_reg_i), .demand_o(sub)
  );

  for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
    rat_file_ctr #(
      .CNT_W(CNT_W), .CAP(int'(FILE_CAP[f*CNT_W +: CNT_W]))
    ) i_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .add_i  (add[f*CNT_W +: CNT_W]),
      .sub_i  (sub[f*CNT_W +: CNT_W]),
      .need_i (need[f*CNT_W +: CNT_W]),
      .used_o (used_o[f*CNT_W +: CNT_W]),
      .busy_o (busy_o[f]),
      .uflow_o(uflow_o[f])
    );
  end

  always_comb begin
    tbl_owner_o = FIDX_W'(owner_of(32'(tbl_idx_i), NUM_LREGS, NUM_FILES));
    tbl_cost_o  = COST_W'(cost_of(32'(tbl_idx_i), NUM_LREGS, NUM_FILES,
                                  WIDE_FILE));
  end

  // R5
  zero_idiom_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_stb_i && !rel_stb_i && ((alloc_en_i & ~alloc_zero_i) == '0))
      |=> $stable(used_o));

endmodule

// File: tb/test_rat_alloc_tracker.sv
module test_rat_alloc_tracker;
  localparam int NF = 4;
  localparam int CW = 8;
  localparam int NV = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] q_en = '0, q_zero = '0, a_en = '0, a_zero = '0;
  logic [1:0] r_en = '0, r_zero = '0;
  logic [7:0] q_reg = '0, a_reg = '0, r_reg = '0;
  logic a_stb = 1'b0, r_stb = 1'b0;
  logic [3:0] tbl_idx = '0;
  logic [NF-1:0] busy, uflow;
  logic [NF*CW-1:0] used;
  logic [1:0] tbl_owner, tbl_cost;

  int checks = 0;
  int fails  = 0;
  int model_used [NF];
  int model_uf   [NF];

  always #4 clk = ~clk;

  rat_alloc_tracker i_rat_alloc_tracker (
    .clk(clk), .rst_n(rst_n),
    .q_en_i(q_en), .q_zero_i(q_zero), .q_reg_i(q_reg), .busy_o(busy),
    .alloc_stb_i(a_stb), .alloc_en_i(a_en), .alloc_zero_i(a_zero),
    .alloc_reg_i(a_reg),
    .rel_stb_i(r_stb), .rel_en_i(r_en), .rel_zero_i(r_zero),
    .rel_reg_i(r_reg),
    .used_o(used), .uflow_o(uflow),
    .tbl_idx_i(tbl_idx), .tbl_owner_o(tbl_owner), .tbl_cost_o(tbl_cost)
  );

  // {a_en,a_zero,a_r1,a_r0, r_en,r_zero,r_r1,r_r0, q_en,q_zero,q_r1,q_r0, busy}
  localparam logic [39:0] VEC [NV] = '{
    {2'b11,2'b00,4'd5,4'd4,   2'b00,2'b00,4'd0,4'd0,  2'b11,2'b00,4'd9,4'd8,   4'b0000},
    {2'b11,2'b00,4'd9,4'd8,   2'b00,2'b00,4'd0,4'd0,  2'b01,2'b00,4'd0,4'd10,  4'b0100},
    {2'b11,2'b11,4'd7,4'd6,   2'b00,2'b00,4'd0,4'd0,  2'b11,2'b00,4'd5,4'd4,   4'b0000},
    {2'b11,2'b00,4'd7,4'd6,   2'b00,2'b00,4'd0,4'd0,  2'b11,2'b00,4'd5,4'd4,   4'b0000},
    {2'b00,2'b00,4'd0,4'd0,   2'b00,2'b00,4'd0,4'd0,  2'b11,2'b00,4'd8,4'd4,   4'b0100},
    {2'b00,2'b00,4'd0,4'd0,   2'b00,2'b00,4'd0,4'd0,  2'b11,2'b11,4'd10,4'd9,  4'b0000},
    {2'b11,2'b00,4'd13,4'd12, 2'b00,2'b00,4'd0,4'd0,  2'b11,2'b00,4'd15,4'd14, 4'b0000},
    {2'b01,2'b00,4'd0,4'd4,   2'b01,2'b00,4'd0,4'd8,  2'b11,2'b00,4'd5,4'd4,   4'b0010},
    {2'b00,2'b00,4'd0,4'd0,   2'b01,2'b01,4'd0,4'd9,  2'b11,2'b00,4'd11,4'd10, 4'b0100},
    {2'b00,2'b00,4'd0,4'd0,   2'b01,2'b00,4'd0,4'd9,  2'b11,2'b00,4'd11,4'd10, 4'b0000},
    {2'b00,2'b00,4'd0,4'd0,   2'b01,2'b00,4'd0,4'd8,  2'b11,2'b01,4'd11,4'd10, 4'b0000}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model: owner r/4, cost 2 in file 2, file 0 sees all
  task automatic model_step(input logic [1:0] ae, input logic [1:0] az,
                            input logic [7:0] ar, input logic [1:0] re,
                            input logic [1:0] rz, input logic [7:0] rr);
    int add [NF];
    int sub [NF];
    for (int f = 0; f < NF; f++) begin add[f] = 0; sub[f] = 0; end
    for (int g = 0; g < 2; g++) begin
      int r, o, c;
      r = int'(ar[g*4 +: 4]); o = r / 4; c = (o == 2) ? 2 : 1;
      if (ae[g] && !az[g]) begin add[0] += c; if (o != 0) add[o] += c; end
      r = int'(rr[g*4 +: 4]); o = r / 4; c = (o == 2) ? 2 : 1;
      if (re[g] && !rz[g]) begin sub[0] += c; if (o != 0) sub[o] += c; end
    end
    for (int f = 0; f < NF; f++) begin
      int t;
      t = model_used[f] + add[f];
      model_uf[f] = (sub[f] > t) ? 1 : 0;
      model_used[f] = (sub[f] > t) ? 0 : t - sub[f];
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    for (int f = 0; f < NF; f++) begin model_used[f] = 0; model_uf[f] = 0; end
    repeat (2) @(negedge clk);
    // R1 reset state
    q_en = 2'b11; q_reg = {4'd9, 4'd8};
    #1;
    for (int f = 0; f < NF; f++) chk("R1 used", int'(used[f*CW +: CW]), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 uflow", int'(uflow), 0);
    rst_n = 1'b1;
    // R2 lookup table
    tbl_idx = 4'd9;  #1;
    chk("R2 owner r9", int'(tbl_owner), 2); chk("R2 cost r9", int'(tbl_cost), 2);
    tbl_idx = 4'd2;  #1;
    chk("R2 owner r2", int'(tbl_owner), 0); chk("R2 cost r2", int'(tbl_cost), 1);
    tbl_idx = 4'd13; #1;
    chk("R2 owner r13", int'(tbl_owner), 3); chk("R2 cost r13", int'(tbl_cost), 1);

    // vector walk: covers R3 R4 R5 R6 R7 R8 R9 R10
    @(negedge clk);
    for (int v = 0; v < NV; v++) begin
      logic [39:0] e;
      e = VEC[v];
      a_en = e[39:38]; a_zero = e[37:36]; a_reg = e[35:28];
      r_en = e[27:26]; r_zero = e[25:24]; r_reg = e[23:16];
      q_en = e[15:14]; q_zero = e[13:12]; q_reg = e[11:4];
      a_stb = |a_en; r_stb = |r_en;
      model_step(a_en, a_zero, a_reg, r_en, r_zero, r_reg);
      @(negedge clk);
      for (int f = 0; f < NF; f++) begin
        chk($sformatf("R3 R4 R9 used v%0d f%0d", v, f),
            int'(used[f*CW +: CW]), model_used[f]);
        chk($sformatf("R10 uflow v%0d f%0d", v, f), int'(uflow[f]), model_uf[f]);
      end
      chk($sformatf("R6 R7 R8 busy v%0d", v), int'(busy), int'(e[3:0]));
    end
    a_stb = 1'b0; r_stb = 1'b0; a_en = '0; r_en = '0;

    // R10 flag lasts one cycle only
    @(negedge clk);
    chk("R10 uflow clears", int'(uflow), 0);

    // R7 unbounded file 3 with large demand: allocate many, never busy
    for (int k = 0; k < 6; k++) begin
      a_stb = 1'b1; a_en = 2'b11; a_zero = 2'b00; a_reg = {4'd15, 4'd14};
      @(negedge clk);
    end
    a_stb = 1'b0; a_en = '0;
    q_en = 2'b11; q_zero = 2'b00; q_reg = {4'd13, 4'd12}; #1;
    chk("R7 unbounded used f3", int'(used[3*CW +: CW]), 14);
    chk("R7 unbounded busy", int'(busy), 0);

    // R1 reset mid-run clears counts
    rst_n = 1'b0; #1;
    chk("R1 used after reset", int'(used), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 stays clear", int'(used), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule